// File: doc/BRIEF.md
# Register-Mapped Message Queue

This block is a small queue of 32-bit messages that a processor drains through a plain register slave port. Internal logic loads new words through a one-cycle push input. The processor sees the queue in four ways. A range of pop addresses removes and returns the oldest word. A peek address returns the oldest word and leaves it in place. A status word flags the full and empty states. A configuration word holds the data-available interrupt enable and a pending bit that tracks whether the queue holds anything.

A read of an empty queue does not stall and does not fault. It returns the fixed marker 0xFFFF_FFFF. Slots that hold no message also carry that marker, so a peek at an empty queue gives the same value. One level interrupt line tells the processor that data is waiting. Only the low eight bits of the bus address are decoded, so the register set repeats every 256 bytes. Read data is registered.

Top module: `msgq_regs`

## Requirements
- R1: After reset the queue holds no entries, the config word reads 0x0000_0000, the status word reads 0x4000_0000, a peek returns 0xFFFF_FFFF and `irq` is 0.
- R2: A read at any low-byte offset from 0x80 to 0x8C inclusive returns the oldest entry and removes it. Successive pops return the words in the order they were pushed.
- R3: A pop read of an empty queue returns 0xFFFF_FFFF and leaves the queue empty.
- R4: A read at offset 0x90 returns the oldest entry, or 0xFFFF_FFFF when the queue is empty, and does not remove it.
- R5: The status word at offset 0x98 has bit 31 set exactly when the queue holds DEPTH entries and bit 30 set exactly when it holds none. All its other bits are 0.
- R6: A write to offset 0x9C changes only config bit 0, the interrupt enable. Config bits 31:5 and 3:1 always read 0.
- R7: Config bit 4, the pending bit, reads 1 exactly when the queue is not empty.
- R8: `irq` is a register. On each clock edge it takes the value of (config bit 0 AND queue not empty) as it stood before that edge, so it follows a change one cycle later.
- R9: Offset 0x94 and every undecoded offset read as 0. Writes to any offset other than 0x9C, including the pop, peek and status offsets, change nothing.
- R10: Address bits above bit 7 are ignored, so an offset plus any multiple of 0x100 reaches the same register.
- R11: A push to a full queue is dropped when no pop happens in the same cycle. A push in the same cycle as a pop of a full queue is kept, and the word goes to the tail.
- R12: `bus_rdata` shows the read result in the cycle after the read strobe and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address. Only bits 7:0 are decoded |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| push_valid | input | 1 | Load `push_data` into the queue tail |
| push_data | input | 32 | Word to enqueue |
| irq | output | 1 | Registered data-available interrupt |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are never high in the same cycle. Their checks on the entry count also assume that no push arrives during the pop, peek or write access being checked, so that any change in the count comes from the access alone. The bench drives each bus access as a one-cycle strobe from a task and never overlaps a read with a write. It raises `push_valid` together with a read only in the one scenario written for that case, a pop of a full queue.

// File: rtl/msgq_pkg.sv
package msgq_pkg;

  localparam logic [31:0] MSGQ_INVALID = 32'hFFFF_FFFF;

  localparam logic [7:0] OFS_POP_FIRST = 8'h80;
  localparam logic [7:0] OFS_POP_LAST  = 8'h8C;
  localparam logic [7:0] OFS_PEEK      = 8'h90;
  localparam logic [7:0] OFS_STATUS    = 8'h98;
  localparam logic [7:0] OFS_CONFIG    = 8'h9C;

  localparam int STAT_FULL_BIT  = 31;
  localparam int STAT_EMPTY_BIT = 30;
  localparam int CFG_EN_BIT     = 0;
  localparam int CFG_PEND_BIT   = 4;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_POP,
    SEL_PEEK,
    SEL_STATUS,
    SEL_CONFIG
  } msgq_sel_e;

endpackage

// File: rtl/msgq_decode.sv
module msgq_decode
  import msgq_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output msgq_sel_e         sel
);

  logic [7:0] low_ofs;
  logic       unused_addr;

  assign low_ofs     = addr[7:0];
  assign unused_addr = ^addr;

  always_comb begin
    sel = SEL_NONE;
    if (low_ofs >= OFS_POP_FIRST && low_ofs <= OFS_POP_LAST) begin
      sel = SEL_POP;
    end else begin
      case (low_ofs)
        OFS_PEEK:   sel = SEL_PEEK;
        OFS_STATUS: sel = SEL_STATUS;
        OFS_CONFIG: sel = SEL_CONFIG;
        default:    sel = SEL_NONE;
      endcase
    end
  end

endmodule

// File: rtl/msgq_store.sv
module msgq_store
  import msgq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty
);

  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [CNT_W-1:0]  count_q;
  logic              pop_ok;
  logic              push_ok;

  assign empty   = (count_q == '0);
  assign full    = (count_q == CNT_W'(DEPTH));
  assign pop_ok  = pop && !empty;
  assign push_ok = push && (!full || pop_ok);
  assign head    = slot_q[0];
  assign count   = count_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] slot_d;

    if (i == DEPTH - 1) begin : g_tail
      assign shifted = DATA_W'(MSGQ_INVALID);
    end else begin : g_body
      assign shifted = slot_q[i+1];
    end

    always_comb begin
      slot_d = slot_q[i];
      if (pop_ok) begin
        slot_d = shifted;
        if (push_ok && count_q == CNT_W'(i + 1)) begin
          slot_d = push_data;
        end
      end else if (push_ok && count_q == CNT_W'(i)) begin
        slot_d = push_data;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        slot_q[i] <= DATA_W'(MSGQ_INVALID);
      end else begin
        slot_q[i] <= slot_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else begin
      case ({push_ok, pop_ok})
        2'b10:   count_q <= count_q + CNT_W'(1);
        2'b01:   count_q <= count_q - CNT_W'(1);
        default: count_q <= count_q;
      endcase
    end
  end

endmodule

// File: rtl/msgq_irq.sv
module msgq_irq (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic pending,
  output logic irq
);

  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= enable && pending;
    end
  end

  assign irq = irq_q;

endmodule

// File: rtl/msgq_regs.sv
module msgq_regs
  import msgq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 12,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              push_valid,
  input  logic [31:0]       push_data,
  output logic              irq
);

  msgq_sel_e        sel;
  logic [31:0]      head;
  logic [CNT_W-1:0] q_count;
  logic             q_full;
  logic             q_empty;
  logic             cfg_en_q;
  logic [31:0]      rd_mux;
  logic [31:0]      rdata_q;
  logic             unused_wdata;

  assign unused_wdata = ^bus_wdata[31:1];

  msgq_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (bus_addr),
    .sel  (sel)
  );

  msgq_store #(.DEPTH(DEPTH), .DATA_W(32)) u_store (
    .clk       (clk),
    .rst       (rst),
    .push      (push_valid),
    .push_data (push_data),
    .pop       (bus_rd && sel == SEL_POP),
    .head      (head),
    .count     (q_count),
    .full      (q_full),
    .empty     (q_empty)
  );

  msgq_irq u_irq (
    .clk     (clk),
    .rst     (rst),
    .enable  (cfg_en_q),
    .pending (!q_empty),
    .irq     (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_en_q <= 1'b0;
    end else if (bus_wr && sel == SEL_CONFIG) begin
      cfg_en_q <= bus_wdata[CFG_EN_BIT];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_POP:    rd_mux = q_empty ? MSGQ_INVALID : head;
      SEL_PEEK:   rd_mux = head;
      SEL_STATUS: begin
        rd_mux[STAT_FULL_BIT]  = q_full;
        rd_mux[STAT_EMPTY_BIT] = q_empty;
      end
      SEL_CONFIG: begin
        rd_mux[CFG_EN_BIT]   = cfg_en_q;
        rd_mux[CFG_PEND_BIT] = !q_empty;
      end
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      rdata_q <= rd_mux;
    end
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/msgq_regs_chk.sv
module msgq_regs_chk
  import msgq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 12,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic              push_valid,
  input logic [31:0]       bus_rdata,
  input logic              irq,
  input logic [CNT_W-1:0]  q_count,
  input logic              cfg_en
);

  logic is_pop;
  logic is_peek;
  logic is_cfg;

  assign is_pop  = bus_addr[7:0] >= OFS_POP_FIRST && bus_addr[7:0] <= OFS_POP_LAST;
  assign is_peek = bus_addr[7:0] == OFS_PEEK;
  assign is_cfg  = bus_addr[7:0] == OFS_CONFIG;

  // R2: a pop of a non-empty queue lowers the count by one
  p_pop_drops_one_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && is_pop && q_count != '0 && !push_valid) |=> q_count == $past(q_count) - CNT_W'(1));

  // R3: a pop of an empty queue returns the marker and leaves it empty
  p_empty_pop_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && is_pop && q_count == '0 && !push_valid) |=> (q_count == '0 && bus_rdata == MSGQ_INVALID));

  // R4: a peek never removes anything
  p_peek_keeps_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && is_peek && !push_valid) |=> $stable(q_count));

  // R5: the count never exceeds the depth
  p_count_bound_r5: assert property (@(posedge clk) disable iff (rst)
    q_count <= CNT_W'(DEPTH));

  // R6: the reserved config bits read as zero
  p_cfg_reserved_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && is_cfg) |=> (bus_rdata[31:5] == '0 && bus_rdata[3:1] == '0));

  // R8: irq follows enable and non-empty one cycle later
  p_irq_set_r8: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && q_count != '0) |=> irq);

  p_irq_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en || q_count == '0) |=> !irq);

  // R9: bus writes never change the queue occupancy
  p_write_no_push_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_rd && !push_valid) |=> $stable(q_count));

endmodule

bind msgq_regs msgq_regs_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_addr   (bus_addr),
  .bus_rd     (bus_rd),
  .bus_wr     (bus_wr),
  .push_valid (push_valid),
  .bus_rdata  (bus_rdata),
  .irq        (irq),
  .q_count    (q_count),
  .cfg_en     (cfg_en_q)
);

// File: tb/msgq_regs_tb.sv
module msgq_regs_tb_top;

  localparam int DEPTH  = 8;
  localparam int ADDR_W = 12;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_rd = 1'b0;
  logic              bus_wr = 1'b0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              push_valid = 1'b0;
  logic [31:0]       push_data = '0;
  logic              irq;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  msgq_regs #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .push_valid (push_valid),
    .push_data  (push_data),
    .irq        (irq)
  );

  localparam logic [31:0] INV      = 32'hFFFF_FFFF;
  localparam logic [31:0] ST_EMPTY = 32'h4000_0000;
  localparam logic [31:0] ST_FULL  = 32'h8000_0000;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    bus_rd   = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d      = bus_rdata;
  endtask

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] v);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = v;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic push_word(input logic [31:0] v);
    @(negedge clk);
    push_data  = v;
    push_valid = 1'b1;
    @(negedge clk);
    push_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", {31'b0, irq}, 32'h0);
    bus_read(12'h098, d); chk("R1 status", d, ST_EMPTY);
    bus_read(12'h09C, d); chk("R1 config", d, 32'h0);
    bus_read(12'h090, d); chk("R1 peek", d, INV);
  endtask

  task automatic t_order();
    logic [31:0] d;
    push_word(32'hA000_0001);
    push_word(32'hA000_0002);
    push_word(32'hA000_0003);
    bus_read(12'h098, d); chk("R5 partial status", d, 32'h0);
    bus_read(12'h090, d); chk("R4 peek", d, 32'hA000_0001);
    bus_read(12'h090, d); chk("R4 peek again", d, 32'hA000_0001);
    bus_read(12'h080, d); chk("R2 pop 0x80", d, 32'hA000_0001);
    bus_read(12'h08C, d); chk("R2 pop 0x8C", d, 32'hA000_0002);
    bus_read(12'h084, d); chk("R2 pop 0x84", d, 32'hA000_0003);
    bus_read(12'h098, d); chk("R5 empty again", d, ST_EMPTY);
  endtask

  task automatic t_empty_pop();
    logic [31:0] d;
    bus_read(12'h088, d); chk("R3 empty pop", d, INV);
    bus_read(12'h098, d); chk("R3 still empty", d, ST_EMPTY);
    bus_read(12'h090, d); chk("R3 peek empty", d, INV);
  endtask

  task automatic t_full();
    logic [31:0] d;
    for (int i = 0; i < DEPTH; i++) push_word(32'hD000_0000 + i);
    bus_read(12'h098, d); chk("R5 full", d, ST_FULL);
    push_word(32'hBAD0_BAD0);
    bus_read(12'h098, d); chk("R11 still full", d, ST_FULL);
    for (int i = 0; i < DEPTH; i++) begin
      bus_read(12'h080, d); chk("R11 drain order", d, 32'hD000_0000 + i);
    end
    bus_read(12'h080, d); chk("R11 dropped word absent", d, INV);
  endtask

  task automatic t_push_pop_full();
    logic [31:0] d;
    for (int i = 0; i < DEPTH; i++) push_word(32'hE000_0000 + i);
    @(negedge clk);
    bus_addr   = 12'h080;
    bus_rd     = 1'b1;
    push_data  = 32'hE0E0_E0E0;
    push_valid = 1'b1;
    @(negedge clk);
    bus_rd     = 1'b0;
    push_valid = 1'b0;
    chk("R11 simultaneous pop", bus_rdata, 32'hE000_0000);
    bus_read(12'h098, d); chk("R11 full after swap", d, ST_FULL);
    for (int i = 1; i < DEPTH; i++) begin
      bus_read(12'h080, d); chk("R11 remaining", d, 32'hE000_0000 + i);
    end
    bus_read(12'h080, d); chk("R11 tail word", d, 32'hE0E0_E0E0);
  endtask

  task automatic t_config();
    logic [31:0] d;
    bus_write(12'h09C, 32'hFFFF_FFFF);
    bus_read(12'h09C, d); chk("R6 only enable set", d, 32'h0000_0001);
    push_word(32'h1234_5678);
    bus_read(12'h09C, d); chk("R7 pending set", d, 32'h0000_0011);
    bus_read(12'h080, d);
    bus_read(12'h09C, d); chk("R7 pending clear", d, 32'h0000_0001);
    bus_write(12'h09C, 32'h0);
    bus_read(12'h09C, d); chk("R6 enable cleared", d, 32'h0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    bus_write(12'h09C, 32'h1);
    @(negedge clk);
    chk("R8 empty no irq", {31'b0, irq}, 32'h0);
    push_word(32'h5555_0000);
    chk("R8 irq lags push", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R8 irq after push", {31'b0, irq}, 32'h1);
    bus_write(12'h09C, 32'h0);
    chk("R8 irq lags disable", {31'b0, irq}, 32'h1);
    @(negedge clk);
    chk("R8 irq disabled", {31'b0, irq}, 32'h0);
    bus_write(12'h09C, 32'h1);
    @(negedge clk);
    chk("R8 irq re-enabled", {31'b0, irq}, 32'h1);
    bus_read(12'h080, d);
    chk("R8 irq lags pop", {31'b0, irq}, 32'h1);
    @(negedge clk);
    chk("R8 irq after pop", {31'b0, irq}, 32'h0);
    bus_write(12'h09C, 32'h0);
  endtask

  task automatic t_unsupported();
    logic [31:0] d;
    push_word(32'h7777_0001);
    bus_read(12'h094, d); chk("R9 sender zero", d, 32'h0);
    bus_read(12'h0A0, d); chk("R9 undecoded zero", d, 32'h0);
    bus_read(12'h091, d); chk("R9 misaligned zero", d, 32'h0);
    bus_write(12'h094, 32'hFFFF_FFFF);
    bus_write(12'h080, 32'h9999_9999);
    bus_write(12'h090, 32'h9999_9999);
    bus_write(12'h098, 32'hFFFF_FFFF);
    bus_write(12'h0A0, 32'h0000_0001);
    bus_read(12'h09C, d); chk("R9 config untouched", d, 32'h0000_0010);
    bus_read(12'h090, d); chk("R9 head untouched", d, 32'h7777_0001);
    bus_read(12'h080, d); chk("R9 pop original", d, 32'h7777_0001);
    bus_read(12'h098, d); chk("R9 no extra entry", d, ST_EMPTY);
  endtask

  task automatic t_alias();
    logic [31:0] d;
    push_word(32'h4242_4242);
    bus_read(12'h398, d); chk("R10 status alias", d, 32'h0);
    bus_read(12'h190, d); chk("R10 peek alias", d, 32'h4242_4242);
    bus_read(12'hF80, d); chk("R10 pop alias", d, 32'h4242_4242);
    bus_read(12'hE98, d); chk("R10 empty alias", d, ST_EMPTY);
  endtask

  task automatic t_hold();
    logic [31:0] d;
    push_word(32'hC0DE_0001);
    bus_read(12'h090, d); chk("R12 read data", d, 32'hC0DE_0001);
    push_word(32'hC0DE_0002);
    repeat (3) @(negedge clk);
    chk("R12 data held", bus_rdata, 32'hC0DE_0001);
    bus_read(12'h080, d);
    bus_read(12'h080, d); chk("R12 second word", d, 32'hC0DE_0002);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_order();
    t_empty_pop();
    t_full();
    t_push_pop_full();
    t_config();
    t_irq();
    t_unsupported();
    t_alias();
    t_hold();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule